// File: doc/BRIEF.md
# Multiplierless Approximate 8-Point Forward DCT Core

This block computes an unnormalized 8-point forward discrete cosine transform of eight signed residual samples. It uses a fast factorization derived from a 16-point Fourier transform of the mirrored input, so the whole transform costs 29 additions or subtractions and five constant products. Each constant product is a fixed shift-and-add network on a coefficient quantized to 8 fractional bits. The network's output is shifted right by those 8 bits, and since that shift is fixed it costs only wiring.

The per-coefficient scale factors are not applied inside the core. A downstream quantizer absorbs them. Output k equals the true sum of x(n)·cos((2n+1)kπ/16) multiplied by 1 for k = 0 and by 2·cos(kπ/16) for k > 0. Internal nodes carry enough guard bits that no intermediate value wraps. Only the final results are clamped to the signed sample width.

The core takes one vector per cycle. With the default setting it presents the result one clock later, together with a valid flag.

Top module: `dct8_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid` becomes 0 and every output coefficient becomes 0 on that edge.
- R2: With the output register enabled (default), `out_valid` equals the `in_valid` of the previous cycle. The result of a vector accepted at one edge appears after the next edge.
- R3: Coefficient 0 equals the exact sum of the eight inputs, clamped to the range -32768..32767.
- R4: Coefficient 4 equals exactly (x0+x3+x4+x7) − (x1+x2+x5+x6), clamped to -32768..32767.
- R5: Coefficients 1, 2, 3, 5, 6 and 7 match C_k·2·cos(kπ/16), clamped to 16 bits. Here C_k = Σ x(n)·cos((2n+1)kπ/16). The allowed error is 4 + (Σ|x(n)|)/64 LSB, which comes from constants quantized as floor(α·256) and from truncating shifts.
- R6: When all eight inputs are equal, every coefficient 1..7 is exactly 0, including at the extreme values +32767 and -32768. Results that exceed the 16-bit range saturate rather than wrap.
- R7: While `in_valid` is low, the registered coefficients keep their previous value whatever the inputs do.
- R8: Sample n occupies bits [16n+15:16n] of `in_samp`, and coefficient k occupies bits [16k+15:16k] of `out_coef`, both in natural order 0..7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input vector is valid this cycle |
| in_samp | input | 128 | Eight signed 16-bit samples, sample n at bits [16n+15:16n] |
| out_valid | output | 1 | Output vector is valid |
| out_coef | output | 128 | Eight signed 16-bit unnormalized coefficients, coefficient k at bits [16k+15:16k] |

## Verification
Several behaviours are exact and are checked on every cycle:
- the one-cycle valid latency;
- the reset clearing;
- the hold while idle;
- the two multiplier-free coefficients 0 and 4, compared against sums formed independently from the inputs;
- the exact zero of all AC terms for a flat input.

The accuracy of the six coefficients that pass through the quantized constants can only be shown by the bench's scenarios. These compare each result against a floating-point transform within the stated error bound. They cover impulses at every position, ramps, alternating extremes, constant maximum and minimum vectors, and pseudo-random vectors.

// File: rtl/dct8_pkg.sv
// Shared constants and types for the 8-point DCT core.
// Assumes a fixed coefficient precision; the shift-add networks are built for it.
package dct8_pkg;
    localparam int NPT   = 8;  // transform length
    localparam int HALF  = NPT / 2;
    localparam int NQ    = 8;  // fractional bits of the rotation constants
    localparam int GUARD = 5;  // growth bits above the sample width

    // Rotation constants, as floor(alpha * 2^NQ):
    // K_C4 = 181 (cos 4pi/16), K_DIFF = 138 (cos 2pi/16 - cos 6pi/16),
    // K_SUM = 334 (cos 2pi/16 + cos 6pi/16), K_C6 = 97 (cos 6pi/16)
    typedef enum logic [1:0] {K_C4, K_DIFF, K_SUM, K_C6} kconst_e;
endpackage

// File: rtl/dct8_cmul.sv
// Constant multiplier: p = floor(a * K / 2^NQ) using shifts and adds only.
// Assumes NQ = 8; the product width leaves room for the largest constant.
module dct8_cmul #(
    parameter int IW = 21,
    parameter dct8_pkg::kconst_e KSEL = dct8_pkg::K_C4
) (
    input  logic signed [IW-1:0] a,
    output logic signed [IW-1:0] p
);
    localparam int PW = IW + dct8_pkg::NQ + 2;

    logic signed [PW-1:0] x;
    logic signed [PW-1:0] prod;

    // Sign-extend the operand into the product width.
    assign x = {{(PW-IW){a[IW-1]}}, a};

    generate
        if (KSEL == dct8_pkg::K_C4) begin : g_c4
            logic signed [PW-1:0] x3;
            // 181x = x + ((48x - 3x) << 2)
            always_comb begin
                x3   = (x <<< 2) - x;
                prod = x + (((x3 <<< 4) - x3) <<< 2);
            end
        end else if (KSEL == dct8_pkg::K_DIFF) begin : g_diff
            // 138x = (x + 4x + 64x) << 1
            always_comb prod = (x + (x <<< 2) + (x <<< 6)) <<< 1;
        end else if (KSEL == dct8_pkg::K_SUM) begin : g_sum
            logic signed [PW-1:0] x5;
            // 334x = ((8x - x) + (5x << 5)) << 1
            always_comb begin
                x5   = x + (x <<< 2);
                prod = (((x <<< 3) - x) + (x5 <<< 5)) <<< 1;
            end
        end else begin : g_c6
            // 97x = x + (3x << 5)
            always_comb prod = x + (((x <<< 2) - x) <<< 5);
        end
    endgenerate

    // Arithmetic right shift by NQ, done by taking bits.
    assign p = prod[dct8_pkg::NQ +: IW];
endmodule

// File: rtl/dct8_even.sv
// Even half: from the four mirrored sums, produces coefficients 0, 2, 4, 6.
// Assumes inputs already carry enough guard bits for two more additions.
module dct8_even #(
    parameter int IW = 21
) (
    input  logic signed [IW-1:0] s [dct8_pkg::HALF],
    output logic signed [IW-1:0] y0,
    output logic signed [IW-1:0] y2,
    output logic signed [IW-1:0] y4,
    output logic signed [IW-1:0] y6
);
    logic signed [IW-1:0] e_a, e_b, e_c, e_d, rot_in, rot_out;

    // Second butterfly level and the multiplier-free outputs.
    always_comb begin
        e_a    = s[0] + s[3];
        e_d    = s[0] - s[3];
        e_b    = s[1] + s[2];
        e_c    = s[1] - s[2];
        rot_in = e_c + e_d;
        y0     = e_a + e_b;
        y4     = e_a - e_b;
    end

    dct8_cmul #(.IW(IW), .KSEL(dct8_pkg::K_C4)) u_rot (.a(rot_in), .p(rot_out));

    // Combine the rotated term into coefficients 2 and 6.
    always_comb begin
        y2 = e_d + rot_out;
        y6 = e_d - rot_out;
    end
endmodule

// File: rtl/dct8_odd.sv
// Odd half: from the four mirrored differences, produces coefficients 1, 3, 5, 7.
// Uses four of the five constant multipliers; d[i] = x(i) - x(7-i).
module dct8_odd #(
    parameter int IW = 21
) (
    input  logic signed [IW-1:0] d [dct8_pkg::HALF],
    output logic signed [IW-1:0] y1,
    output logic signed [IW-1:0] y3,
    output logic signed [IW-1:0] y5,
    output logic signed [IW-1:0] y7
);
    logic signed [IW-1:0] o_lo, o_mid, o_hi, shared_in;
    logic signed [IW-1:0] m_shared, m_lo, m_hi, m_mid;
    logic signed [IW-1:0] z_lo, z_hi, q_p, q_m;

    // Pairwise sums feeding the rotations.
    always_comb begin
        o_lo      = d[3] + d[2];
        o_mid     = d[2] + d[1];
        o_hi      = d[1] + d[0];
        shared_in = o_lo - o_hi;
    end

    dct8_cmul #(.IW(IW), .KSEL(dct8_pkg::K_C6))   u_shared (.a(shared_in), .p(m_shared));
    dct8_cmul #(.IW(IW), .KSEL(dct8_pkg::K_DIFF)) u_lo     (.a(o_lo),      .p(m_lo));
    dct8_cmul #(.IW(IW), .KSEL(dct8_pkg::K_SUM))  u_hi     (.a(o_hi),      .p(m_hi));
    dct8_cmul #(.IW(IW), .KSEL(dct8_pkg::K_C4))   u_mid    (.a(o_mid),     .p(m_mid));

    // Final odd butterflies.
    always_comb begin
        z_lo = m_lo + m_shared;
        z_hi = m_hi + m_shared;
        q_p  = d[0] + m_mid;
        q_m  = d[0] - m_mid;
        y5   = q_m + z_lo;
        y3   = q_m - z_lo;
        y1   = q_p + z_hi;
        y7   = q_p - z_hi;
    end
endmodule

// File: rtl/dct8_core.sv
// Top of the approximate 8-point forward DCT: mirror butterfly, even and odd
// halves, saturation to W bits, optional output register with valid.
// Assumes packed ports with sample/coefficient n at bits [n*W +: W].
module dct8_core #(
    parameter int W       = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [dct8_pkg::NPT*W-1:0]     in_samp,
    output logic                           out_valid,
    output logic [dct8_pkg::NPT*W-1:0]     out_coef
);
    localparam int NPT  = dct8_pkg::NPT;
    localparam int HALF = dct8_pkg::HALF;
    localparam int IW   = W + dct8_pkg::GUARD;
    localparam logic signed [IW-1:0] VMAX = IW'((64'sd1 <<< (W-1)) - 64'sd1);
    localparam logic signed [IW-1:0] VMIN = ~VMAX;

    logic signed [IW-1:0] xs [NPT];
    logic signed [IW-1:0] sm [HALF];
    logic signed [IW-1:0] df [HALF];
    logic signed [IW-1:0] yw [NPT];
    logic [NPT*W-1:0]     sat_bus;

    genvar gi;
    generate
        for (gi = 0; gi < NPT; gi++) begin : g_unpack
            // Sign-extend each sample to the internal width.
            assign xs[gi] = IW'($signed(in_samp[gi*W +: W]));
        end
        for (gi = 0; gi < HALF; gi++) begin : g_mirror
            // Mirror butterfly: x(i) +/- x(7-i).
            assign sm[gi] = xs[gi] + xs[NPT-1-gi];
            assign df[gi] = xs[gi] - xs[NPT-1-gi];
        end
    endgenerate

    dct8_even #(.IW(IW)) u_even (
        .s(sm), .y0(yw[0]), .y2(yw[2]), .y4(yw[4]), .y6(yw[6])
    );
    dct8_odd #(.IW(IW)) u_odd (
        .d(df), .y1(yw[1]), .y3(yw[3]), .y5(yw[5]), .y7(yw[7])
    );

    generate
        for (gi = 0; gi < NPT; gi++) begin : g_sat
            // Clamp each coefficient to the signed W-bit range.
            always_comb begin
                if (yw[gi] > VMAX)
                    sat_bus[gi*W +: W] = VMAX[W-1:0];
                else if (yw[gi] < VMIN)
                    sat_bus[gi*W +: W] = VMIN[W-1:0];
                else
                    sat_bus[gi*W +: W] = yw[gi][W-1:0];
            end
        end

        if (REG_OUT) begin : g_reg
            // Output register: loads on valid, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid <= 1'b0;
                    out_coef  <= '0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid)
                        out_coef <= sat_bus;
                end
            end
        end else begin : g_comb
            // Combinational variant: result follows the inputs directly.
            assign out_valid = in_valid;
            assign out_coef  = sat_bus;
        end
    endgenerate
endmodule

// File: rtl/dct8_core_chk.sv
// Checker for dct8_core: exact coefficients 0 and 4, flat-input zeros,
// valid timing, reset and hold. Bound to every instance of the core.
module dct8_core_chk #(
    parameter int W       = 16,
    parameter bit REG_OUT = 1'b1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic [dct8_pkg::NPT*W-1:0]  in_samp,
    input logic                        out_valid,
    input logic [dct8_pkg::NPT*W-1:0]  out_coef
);
    localparam int NPT = dct8_pkg::NPT;
    localparam int IW  = W + dct8_pkg::GUARD;
    localparam logic signed [IW-1:0] CMAX = IW'((64'sd1 <<< (W-1)) - 64'sd1);

    logic signed [IW-1:0] tot, alt;
    logic [W-1:0]         dc_exp, alt_exp;
    logic                 flat;

    // Independent reference sums for the multiplier-free coefficients.
    always_comb begin
        tot  = '0;
        alt  = '0;
        flat = 1'b1;
        for (int i = 0; i < NPT; i++) begin
            tot = tot + IW'($signed(in_samp[i*W +: W]));
            if (i == 0 || i == 3 || i == 4 || i == 7)
                alt = alt + IW'($signed(in_samp[i*W +: W]));
            else
                alt = alt - IW'($signed(in_samp[i*W +: W]));
            if (in_samp[i*W +: W] != in_samp[W-1:0])
                flat = 1'b0;
        end
        dc_exp  = (tot > CMAX) ? CMAX[W-1:0] : (tot < ~CMAX) ? ~CMAX[W-1:0] : tot[W-1:0];
        alt_exp = (alt > CMAX) ? CMAX[W-1:0] : (alt < ~CMAX) ? ~CMAX[W-1:0] : alt[W-1:0];
    end

    generate
        if (REG_OUT) begin : g_reg_chk
            assert_reset_clear_R1: assert property (@(posedge clk)
                !rst_n |=> (!out_valid && out_coef == '0));
            assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (out_valid == $past(in_valid)));
            assert_dc_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> (out_coef[0 +: W] == $past(dc_exp)));
            assert_mid_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> (out_coef[4*W +: W] == $past(alt_exp)));
            assert_flat_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && flat) |=> (out_coef[NPT*W-1:W] == '0));
            assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> $stable(out_coef));
        end else begin : g_comb_chk
            assert_valid_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid == in_valid);
            assert_dc_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |-> (out_coef[0 +: W] == dc_exp));
            assert_mid_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |-> (out_coef[4*W +: W] == alt_exp));
            assert_flat_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && flat) |-> (out_coef[NPT*W-1:W] == '0));
        end
    endgenerate
endmodule

bind dct8_core dct8_core_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samp(in_samp),
    .out_valid(out_valid), .out_coef(out_coef)
);

// File: tb/test_dct8_core.sv
`timescale 1ns/1ps
// Directed bench for dct8_core with the output register enabled.
module test_dct8_core;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [8*W-1:0] in_samp = '0;
    logic          out_valid;
    logic [8*W-1:0] out_coef;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    int stim [8];
    int seed = 32'h1234_5678;

    dct8_core #(.W(W), .REG_OUT(1'b1)) i_dct8_core (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samp(in_samp),
        .out_valid(out_valid), .out_coef(out_coef)
    );

    always #2 clk = ~clk;  // 250 MHz

    function automatic int coef(input int k);
        return int'($signed(out_coef[k*W +: W]));
    endfunction

    function automatic int clamp16(input real v);
        if (v > 32767.0) return 32767;
        if (v < -32768.0) return -32768;
        return int'(v);
    endfunction

    // Scaled transform reference per R5 (k = 0 uses factor 1).
    function automatic real ref_coef(input int k);
        real acc = 0.0;
        real pi = 3.14159265358979;
        for (int n = 0; n < 8; n++)
            acc += real'(stim[n]) * $cos(real'((2*n+1)*k) * pi / 16.0);
        if (k != 0) acc = acc * 2.0 * $cos(real'(k) * pi / 16.0);
        return acc;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive stim for one cycle; result is registered by the next negedge.
    task automatic apply();
        @(negedge clk);
        for (int i = 0; i < 8; i++) in_samp[i*W +: W] = W'(stim[i]);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R2 valid after one cycle", int'(out_valid), 1);
    endtask

    // Compare all eight outputs against the requirements.
    task automatic check_all(input string tag);
        int sabs = 0;
        int s_all = 0;
        int s_alt = 0;
        for (int n = 0; n < 8; n++) begin
            sabs += (stim[n] < 0) ? -stim[n] : stim[n];
            s_all += stim[n];
            s_alt += (n == 0 || n == 3 || n == 4 || n == 7) ? stim[n] : -stim[n];
        end
        check(coef(0) == clamp16(real'(s_all)), {"R3 dc ", tag}, coef(0), clamp16(real'(s_all)));
        check(coef(4) == clamp16(real'(s_alt)), {"R4 mid ", tag}, coef(4), clamp16(real'(s_alt)));
        for (int k = 1; k < 8; k++) begin
            if (k != 4) begin
                int e = clamp16(ref_coef(k));
                int d = coef(k) - e;
                int tol = 4 + sabs / 64;
                check((d <= tol) && (d >= -tol), {"R5 R8 ac ", tag}, coef(k), e);
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
        check(out_coef == '0, "R1 reset coef", coef(0), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R2 idle after reset", int'(out_valid), 0);
    endtask

    task automatic t_impulses();
        for (int p = 0; p < 8; p++) begin
            for (int i = 0; i < 8; i++) stim[i] = (i == p) ? 1000 : 0;
            apply();
            check_all("impulse");
        end
        for (int i = 0; i < 8; i++) stim[i] = (i == 5) ? -700 : 0;
        apply();
        check_all("neg impulse");
    endtask

    task automatic t_flat();
        for (int i = 0; i < 8; i++) stim[i] = 1234;
        apply();
        check(coef(0) == 9872, "R3 flat dc", coef(0), 9872);
        for (int k = 1; k < 8; k++) check(coef(k) == 0, "R6 flat ac", coef(k), 0);
    endtask

    task automatic t_extremes();
        for (int i = 0; i < 8; i++) stim[i] = 32767;
        apply();
        check(coef(0) == 32767, "R6 all max dc saturates", coef(0), 32767);
        for (int k = 1; k < 8; k++) check(coef(k) == 0, "R6 all max ac", coef(k), 0);
        for (int i = 0; i < 8; i++) stim[i] = -32768;
        apply();
        check(coef(0) == -32768, "R6 all min dc saturates", coef(0), -32768);
        for (int k = 1; k < 8; k++) check(coef(k) == 0, "R6 all min ac", coef(k), 0);
        for (int i = 0; i < 8; i++) stim[i] = (i % 2 == 0) ? 32767 : -32768;
        apply();
        check_all("alternating extremes");
        check(coef(7) == 32767 || coef(7) == -32768, "R6 ac saturates", coef(7), 32767);
    endtask

    task automatic t_patterns();
        for (int i = 0; i < 8; i++) stim[i] = 100 * i - 350;
        apply();
        check_all("ramp");
        for (int i = 0; i < 8; i++) stim[i] = (i < 4) ? 900 : -900;
        apply();
        check_all("step");
        for (int j = 0; j < 40; j++) begin
            for (int i = 0; i < 8; i++) begin
                seed = seed ^ (seed << 13);
                seed = seed ^ (seed >>> 17);
                seed = seed ^ (seed << 5);
                stim[i] = (j < 20) ? ((seed & 4095) - 2048) : ((seed & 511) - 256);
            end
            apply();
            check_all("random");
        end
    endtask

    task automatic t_hold();
        logic [8*W-1:0] snap;
        for (int i = 0; i < 8; i++) stim[i] = 300 + 50 * i;
        apply();
        snap = out_coef;
        for (int c = 0; c < 3; c++) begin
            in_samp = {8{16'h4321}} ^ {8{W'(c)}};
            @(negedge clk);
            check(out_coef == snap, "R7 hold while idle", coef(0), int'($signed(snap[W-1:0])));
            check(out_valid == 1'b0, "R2 valid drops", int'(out_valid), 0);
        end
    endtask

    task automatic t_reset_clears();
        for (int i = 0; i < 8; i++) stim[i] = 777;
        apply();
        rst_n = 1'b0;
        @(negedge clk);
        check(out_coef == '0 && out_valid == 1'b0, "R1 reset clears result", coef(0), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog expired: actual timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_impulses();
        t_flat();
        t_extremes();
        t_patterns();
        t_hold();
        t_reset_clears();
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule